// File: doc/BRIEF.md
# NAND Page-Buffer Single-Bit Error Repair Unit

This unit runs after a page-buffer read engine has moved one sub-buffer of a NAND page into on-chip buffer RAM. For each sub-buffer the read engine presents a 4-bit ECC status word and two error position words, one for the main area and one for the spare area. The hardware corrector upstream repairs a single-bit error in the first of two back-to-back erroneous pages, but it leaves the second one alone. This unit therefore keeps one flag per area that records whether the previous page had a single-bit error. When the current page has one too, the unit repairs it with a read-modify-write that XORs one bit of a 16-bit word in the buffer RAM.

The buffer RAM sits inside the unit. It holds a main region and a spare region for each of up to four sub-buffers. A host port writes and reads it, so the page data can be loaded and the repairs checked. An uncorrectable two-bit report in either area raises a one-cycle flag and leaves that area untouched. While a repair is in progress the status input is not accepted. A done pulse ends every accepted status.

Top module: `nand_ecc_fixer`

## Requirements
- R1: A status word is accepted when `st_valid` and `st_ready` are both high at a clock edge. Bits [3:2] describe the main area and bits [1:0] the spare area. In each field, 2'b01 means one correctable bit error and 2'b10 means an uncorrectable two-bit error.
- R2: Each area has an armed flag. An accepted status whose field for that area is 2'b01 sets the flag. If the flag was clear before that status, the buffer RAM is not modified for that area.
- R3: When the main field is 2'b01, the main flag was already set and the access is not spare-only, the unit flips one bit of main word `buf*MAIN_WORDS + main_pos[11:4]`. The bit index is `main_pos[3:0]`, and the flip is an XOR with a single 1.
- R4: When the spare field is 2'b01 and the spare flag was already set, the unit flips bit `spare_pos[3:0]` of word `NUM_BUFS*MAIN_WORDS + buf*SPARE_WORDS + spare_pos[6:4]`.
- R5: An accepted status whose field for an area is not 2'b01 clears that area's flag. While the single-bit errors keep coming back to back, the flag stays set and every page after the first is repaired.
- R6: With `st_spare_only` high, no main-area repair is made. A main field of 2'b01 still sets the main flag.
- R7: `uncorr_o` goes high for exactly one cycle, starting right after the accepting edge, when either field is 2'b10. No write happens for an area whose field is 2'b10.
- R8: `done_o` is a one-cycle pulse. It is high 2*F cycles after the first cycle following the accepting edge, where F (0, 1 or 2) is the number of repairs. `fixed_main_o` and `fixed_spare_o` show which repairs were made. `st_ready` is low from the accepting edge until `done_o` has been seen. When both areas are repaired, the main repair comes first.
- R9: A status presented while `st_ready` is low has no effect on the flags, on the RAM or on the done pulses.
- R10: After reset, `st_ready` is 1, `done_o` and `uncorr_o` are 0, and both flags are clear.
- R11: The host port addresses main words at 0..NUM_BUFS*MAIN_WORDS-1, followed by the spare words. `host_rdata` is a combinational read of `host_addr`. A repair write takes priority over a host write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Status word present |
| st_ready | output | 1 | Unit idle, able to accept a status |
| st_code | input | 4 | ECC status: [3:2] main, [1:0] spare |
| st_buf | input | BUF_W (2) | Sub-buffer index of this read |
| st_spare_only | input | 1 | Read covered only the spare area |
| main_pos | input | POS_W (16) | Main error position: halfword index above bit 3, bit index in [3:0] |
| spare_pos | input | POS_W (16) | Spare error position, same layout |
| done_o | output | 1 | One-cycle end-of-status pulse |
| fixed_main_o | output | 1 | Main repair made, valid with done_o |
| fixed_spare_o | output | 1 | Spare repair made, valid with done_o |
| uncorr_o | output | 1 | One-cycle uncorrectable error flag |
| host_we | input | 1 | Host write enable for the buffer RAM |
| host_addr | input | ADDR_W (11) | Host word address |
| host_wdata | input | DATA_W (16) | Host write data |
| host_rdata | output | DATA_W (16) | Host read data |

## Verification
Every result has a fixed latency counted from the accepting edge. `uncorr_o` is due in the first cycle after that edge. `done_o` is due 0, 2 or 4 cycles later, for zero, one or two repairs. The changed RAM words can be read once `done_o` has been seen. Before driving each status, the driver records which cycle it expects to be the accepting one. It also pushes the expected repair flags, the expected uncorrectable flag and the expected done latency into a queue. A monitor samples on the falling edge, measures both latencies against that cycle number and compares them with the queued item. The driver then reads the targeted words back through the host port and compares them with a shadow copy that a behavioural model of the two armed flags keeps up to date.

// File: rtl/ecc_fix_pkg.sv
// Package: shared encodings for the NAND single-bit error repair unit.
// Assumes: status fields are 2 bits wide, one per area.
package ecc_fix_pkg;

    // Status field encodings
    localparam logic [1:0] FLD_SINGLE = 2'b01;
    localparam logic [1:0] FLD_DOUBLE = 2'b10;

    // Repair sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_READ  = 2'd1,
        SQ_WRITE = 2'd2,
        SQ_DONE  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/ecc_status_decode.sv
// Module: ecc_status_decode
// Splits an accepted ECC status into per-area decisions, keeps the two
// "previous page had a single-bit error" flags, and turns the error
// position words into buffer RAM word addresses and bit indices.
// Assumes: MAIN_WORDS and SPARE_WORDS are powers of two.
module ecc_status_decode
    import ecc_fix_pkg::*;
#(
    parameter int NUM_BUFS    = 4,
    parameter int MAIN_WORDS  = 256,
    parameter int SPARE_WORDS = 8,
    parameter int POS_W       = 16,
    parameter int BIT_W       = 4,
    parameter int BUF_W       = 2,
    parameter int ADDR_W      = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [3:0]        code,
    input  logic [BUF_W-1:0]  buf_id,
    input  logic              spare_only,
    input  logic [POS_W-1:0]  main_pos,
    input  logic [POS_W-1:0]  spare_pos,
    output logic              fix_main,
    output logic              fix_spare,
    output logic              uncorr,
    output logic [ADDR_W-1:0] main_addr,
    output logic [BIT_W-1:0]  main_bit,
    output logic [ADDR_W-1:0] spare_addr,
    output logic [BIT_W-1:0]  spare_bit
);
    localparam int MAIN_TOTAL = NUM_BUFS * MAIN_WORDS;

    logic [1:0]       main_fld;
    logic [1:0]       spare_fld;
    logic             armed_main;
    logic             armed_spare;
    logic [POS_W-1:0] main_idx;
    logic [POS_W-1:0] spare_idx;

    assign main_fld  = code[3:2];
    assign spare_fld = code[1:0];

    // Per-area flags: set by a single-bit report, cleared by anything else
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_main  <= 1'b0;
            armed_spare <= 1'b0;
        end else if (accept) begin
            armed_main  <= (main_fld == FLD_SINGLE);
            armed_spare <= (spare_fld == FLD_SINGLE);
        end
    end

    // Repair decisions for the status being accepted
    always_comb begin
        fix_main  = accept && (main_fld == FLD_SINGLE) && armed_main && !spare_only;
        fix_spare = accept && (spare_fld == FLD_SINGLE) && armed_spare;
        uncorr    = accept && ((main_fld == FLD_DOUBLE) || (spare_fld == FLD_DOUBLE));
    end

    // Target word addresses and bit indices from the position words
    always_comb begin
        main_idx   = (main_pos >> BIT_W) & POS_W'(MAIN_WORDS - 1);
        spare_idx  = (spare_pos >> BIT_W) & POS_W'(SPARE_WORDS - 1);
        main_addr  = ADDR_W'(buf_id) * ADDR_W'(MAIN_WORDS) + ADDR_W'(main_idx);
        spare_addr = ADDR_W'(MAIN_TOTAL) + ADDR_W'(buf_id) * ADDR_W'(SPARE_WORDS)
                   + ADDR_W'(spare_idx);
        main_bit   = main_pos[BIT_W-1:0];
        spare_bit  = spare_pos[BIT_W-1:0];
    end

endmodule

// File: rtl/ecc_rmw_seq.sv
// Module: ecc_rmw_seq
// Runs up to two read-modify-write repairs per accepted status, main area
// first, each taking one read cycle and one write cycle. Then it pulses done.
// Assumes: the RAM read data is combinational on ram_addr.
module ecc_rmw_seq
    import ecc_fix_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BIT_W  = 4,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    output logic              st_ready,
    input  logic              fix_main,
    input  logic              fix_spare,
    input  logic              uncorr,
    input  logic [ADDR_W-1:0] main_addr,
    input  logic [BIT_W-1:0]  main_bit,
    input  logic [ADDR_W-1:0] spare_addr,
    input  logic [BIT_W-1:0]  spare_bit,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              done_o,
    output logic              fixed_main_o,
    output logic              fixed_spare_o,
    output logic              uncorr_o
);
    seq_state_t        state;
    logic              pend_main;
    logic              pend_spare;
    logic [ADDR_W-1:0] main_addr_q;
    logic [ADDR_W-1:0] spare_addr_q;
    logic [BIT_W-1:0]  main_bit_q;
    logic [BIT_W-1:0]  spare_bit_q;
    logic [BIT_W-1:0]  cur_bit;
    logic [DATA_W-1:0] hold_word;

    // Current repair target: main while pending, else spare
    always_comb begin
        ram_addr = pend_main ? main_addr_q : spare_addr_q;
        cur_bit  = pend_main ? main_bit_q : spare_bit_q;
    end

    assign st_ready  = (state == SQ_IDLE);
    assign ram_we    = (state == SQ_WRITE);
    assign ram_wdata = hold_word;
    assign done_o    = (state == SQ_DONE);

    // Repair state machine with captured targets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= SQ_IDLE;
            pend_main     <= 1'b0;
            pend_spare    <= 1'b0;
            main_addr_q   <= '0;
            spare_addr_q  <= '0;
            main_bit_q    <= '0;
            spare_bit_q   <= '0;
            hold_word     <= '0;
            fixed_main_o  <= 1'b0;
            fixed_spare_o <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (accept) begin
                        pend_main     <= fix_main;
                        pend_spare    <= fix_spare;
                        fixed_main_o  <= fix_main;
                        fixed_spare_o <= fix_spare;
                        main_addr_q   <= main_addr;
                        spare_addr_q  <= spare_addr;
                        main_bit_q    <= main_bit;
                        spare_bit_q   <= spare_bit;
                        state <= (fix_main || fix_spare) ? SQ_READ : SQ_DONE;
                    end
                end
                SQ_READ: begin
                    hold_word <= rd_data ^ (DATA_W'(1) << cur_bit);
                    state     <= SQ_WRITE;
                end
                SQ_WRITE: begin
                    if (pend_main) pend_main <= 1'b0;
                    else           pend_spare <= 1'b0;
                    state <= (pend_main && pend_spare) ? SQ_READ : SQ_DONE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // One-cycle uncorrectable flag after the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n) uncorr_o <= 1'b0;
        else        uncorr_o <= accept && uncorr;
    end

endmodule

// File: rtl/page_buf_ram.sv
// Module: page_buf_ram
// Page buffer storage with a repair port and a host port. Both read
// combinationally. The repair write wins over a host write.
// Assumes: DEPTH fits in ADDR_W bits.
module page_buf_ram #(
    parameter int DEPTH  = 1056,
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              fix_we,
    input  logic [ADDR_W-1:0] fix_addr,
    input  logic [DATA_W-1:0] fix_wdata,
    output logic [DATA_W-1:0] fix_rdata,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    assign fix_rdata  = mem[fix_addr];
    assign host_rdata = mem[host_addr];

    // Single write port, repair first
    always_ff @(posedge clk) begin
        if (fix_we)       mem[fix_addr]  <= fix_wdata;
        else if (host_we) mem[host_addr] <= host_wdata;
    end

endmodule

// File: rtl/nand_ecc_fixer.sv
// Module: nand_ecc_fixer
// Top level of the single-bit error repair unit. It wires the status
// decoder, the read-modify-write sequencer and the page buffer RAM.
// Assumes: DATA_W is 2**BIT_W and the buffer counts are powers of two.
module nand_ecc_fixer #(
    parameter int NUM_BUFS    = 4,
    parameter int MAIN_WORDS  = 256,
    parameter int SPARE_WORDS = 8,
    parameter int DATA_W      = 16,
    parameter int POS_W       = 16,
    localparam int BIT_W      = $clog2(DATA_W),
    localparam int BUF_W      = $clog2(NUM_BUFS),
    localparam int DEPTH      = NUM_BUFS * (MAIN_WORDS + SPARE_WORDS),
    localparam int ADDR_W     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [3:0]        st_code,
    input  logic [BUF_W-1:0]  st_buf,
    input  logic              st_spare_only,
    input  logic [POS_W-1:0]  main_pos,
    input  logic [POS_W-1:0]  spare_pos,
    output logic              done_o,
    output logic              fixed_main_o,
    output logic              fixed_spare_o,
    output logic              uncorr_o,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata
);
    logic              accept;
    logic              dec_fix_main;
    logic              dec_fix_spare;
    logic              dec_uncorr;
    logic [ADDR_W-1:0] dec_main_addr;
    logic [ADDR_W-1:0] dec_spare_addr;
    logic [BIT_W-1:0]  dec_main_bit;
    logic [BIT_W-1:0]  dec_spare_bit;
    logic [ADDR_W-1:0] seq_ram_addr;
    logic              seq_ram_we;
    logic [DATA_W-1:0] seq_ram_wdata;
    logic [DATA_W-1:0] seq_rd_data;

    assign accept = st_valid && st_ready;

    ecc_status_decode #(
        .NUM_BUFS(NUM_BUFS), .MAIN_WORDS(MAIN_WORDS), .SPARE_WORDS(SPARE_WORDS),
        .POS_W(POS_W), .BIT_W(BIT_W), .BUF_W(BUF_W), .ADDR_W(ADDR_W)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .accept(accept), .code(st_code),
        .buf_id(st_buf), .spare_only(st_spare_only),
        .main_pos(main_pos), .spare_pos(spare_pos),
        .fix_main(dec_fix_main), .fix_spare(dec_fix_spare), .uncorr(dec_uncorr),
        .main_addr(dec_main_addr), .main_bit(dec_main_bit),
        .spare_addr(dec_spare_addr), .spare_bit(dec_spare_bit)
    );

    ecc_rmw_seq #(
        .DATA_W(DATA_W), .BIT_W(BIT_W), .ADDR_W(ADDR_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .accept(accept), .st_ready(st_ready),
        .fix_main(dec_fix_main), .fix_spare(dec_fix_spare), .uncorr(dec_uncorr),
        .main_addr(dec_main_addr), .main_bit(dec_main_bit),
        .spare_addr(dec_spare_addr), .spare_bit(dec_spare_bit),
        .rd_data(seq_rd_data), .ram_addr(seq_ram_addr), .ram_we(seq_ram_we),
        .ram_wdata(seq_ram_wdata), .done_o(done_o),
        .fixed_main_o(fixed_main_o), .fixed_spare_o(fixed_spare_o),
        .uncorr_o(uncorr_o)
    );

    page_buf_ram #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_ram (
        .clk(clk), .fix_we(seq_ram_we), .fix_addr(seq_ram_addr),
        .fix_wdata(seq_ram_wdata), .fix_rdata(seq_rd_data),
        .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

endmodule

// File: rtl/nand_ecc_fixer_chk.sv
// Module: nand_ecc_fixer_chk
// Temporal checks on the repair unit, attached to every instance by bind.
module nand_ecc_fixer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       st_valid,
    input logic       st_ready,
    input logic [3:0] st_code,
    input logic       st_spare_only,
    input logic       dec_fix_main,
    input logic       ram_we,
    input logic       done_o,
    input logic       uncorr_o
);
    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_uncorr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        uncorr_o |=> !uncorr_o);

    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready) |=> !st_ready);

    a_r7_no_main_fix_on_double: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && st_code[3:2] == 2'b10) |-> !dec_fix_main);

    a_r6_spare_only_blocks_main: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && st_spare_only) |-> !dec_fix_main);

    a_r9_write_only_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> !st_ready);

endmodule

bind nand_ecc_fixer nand_ecc_fixer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_code(st_code), .st_spare_only(st_spare_only),
    .dec_fix_main(dec_fix_main), .ram_we(seq_ram_we),
    .done_o(done_o), .uncorr_o(uncorr_o)
);

// File: tb/tb_nand_ecc_fixer.sv
module tb_nand_ecc_fixer;
    localparam int CLK_PERIOD = 10;
    localparam int NB  = 4;
    localparam int MW  = 256;
    localparam int SW  = 8;
    localparam int TOT = NB * (MW + SW);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [3:0]  st_code = '0;
    logic [1:0]  st_buf = '0;
    logic        st_spare_only = 1'b0;
    logic [15:0] main_pos = '0;
    logic [15:0] spare_pos = '0;
    logic        done_o, fixed_main_o, fixed_spare_o, uncorr_o;
    logic        host_we = 1'b0;
    logic [10:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;

    nand_ecc_fixer dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_code(st_code), .st_buf(st_buf), .st_spare_only(st_spare_only),
        .main_pos(main_pos), .spare_pos(spare_pos), .done_o(done_o),
        .fixed_main_o(fixed_main_o), .fixed_spare_o(fixed_spare_o),
        .uncorr_o(uncorr_o), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit    fm;
        bit    fs;
        bit    unc;
        int    lat;
        string req;
    } exp_t;

    exp_t        q[$];
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    int          acc_cyc = 0;
    bit          unc_seen = 0;
    int          unc_lat = 0;
    bit          m_armed = 0;
    bit          s_armed = 0;
    bit          finished = 0;
    logic [15:0] shadow [TOT];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Monitor: pops expected items as done pulses appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (uncorr_o) begin
                unc_seen = 1;
                unc_lat  = cyc - acc_cyc;
            end
            if (done_o) begin
                if (q.size() == 0) begin
                    chk(0, "R9", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(fixed_main_o == e.fm, e.req, "fixed_main", fixed_main_o, e.fm);
                    chk(fixed_spare_o == e.fs, e.req, "fixed_spare", fixed_spare_o, e.fs);
                    chk((cyc - acc_cyc) == e.lat, "R8", "done latency", cyc - acc_cyc, e.lat);
                    chk(st_ready == 1'b0, "R8", "ready during done", st_ready, 0);
                    chk(unc_seen == e.unc, "R7", "uncorr pulse", unc_seen, e.unc);
                    if (e.unc) chk(unc_lat == 0, "R7", "uncorr latency", unc_lat, 0);
                end
                unc_seen = 0;
            end
        end
    end

    task automatic check_word(input int a, input string req);
        @(negedge clk);
        host_addr = 11'(a);
        #1;
        chk(host_rdata == shadow[a], req, $sformatf("word %0d", a), host_rdata, shadow[a]);
    endtask

    // Driver: model, push expectation, drive, wait, check RAM targets
    task automatic send(input logic [3:0] code, input logic [1:0] b, input bit so,
                        input logic [15:0] mp, input logic [15:0] sp,
                        input string req, input bit poke);
        exp_t e;
        int ma, sa, nfix;
        ma = int'(b) * MW + int'(mp[11:4]);
        sa = NB * MW + int'(b) * SW + int'(sp[6:4]);
        e.fm = (code[3:2] == 2'b01) && m_armed && !so;
        e.fs = (code[1:0] == 2'b01) && s_armed;
        m_armed = (code[3:2] == 2'b01);
        s_armed = (code[1:0] == 2'b01);
        e.unc = (code[3:2] == 2'b10) || (code[1:0] == 2'b10);
        nfix = int'(e.fm) + int'(e.fs);
        e.lat = 2 * nfix;
        e.req = req;
        if (e.fm) shadow[ma] = shadow[ma] ^ (16'h1 << mp[3:0]);
        if (e.fs) shadow[sa] = shadow[sa] ^ (16'h1 << sp[3:0]);
        q.push_back(e);
        @(negedge clk);
        st_valid = 1'b1; st_code = code; st_buf = b; st_spare_only = so;
        main_pos = mp; spare_pos = sp;
        acc_cyc = cyc + 1;
        @(negedge clk);
        if (poke) begin
            st_code = 4'b0000;
            st_buf = ~b;
            @(negedge clk);
        end
        st_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        check_word(ma, req);
        check_word(sa, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "R8", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle state after reset
        chk(st_ready == 1'b1, "R10", "ready after reset", st_ready, 1);
        chk(done_o == 1'b0, "R10", "done after reset", done_o, 0);
        chk(uncorr_o == 1'b0, "R10", "uncorr after reset", uncorr_o, 0);

        // R11: load buffer RAM through the host port
        for (int i = 0; i < TOT; i++) begin
            shadow[i] = 16'(i * 16'h9E37) ^ 16'h5A5A;
            @(negedge clk);
            host_we = 1'b1; host_addr = 11'(i); host_wdata = shadow[i];
        end
        @(negedge clk);
        host_we = 1'b0;
        check_word(0, "R11");
        check_word(TOT - 1, "R11");

        send(4'b0000, 2'd0, 0, 16'h0000, 16'h0000, "R1", 0);
        send(4'b0100, 2'd1, 0, 16'h0127, 16'h0000, "R2", 0);   // first main: arm only
        send(4'b0100, 2'd2, 0, 16'h03A5, 16'h0000, "R3", 0);   // repair main
        send(4'b0100, 2'd3, 0, 16'h0FFF, 16'h0000, "R5", 0);   // still consecutive
        send(4'b0001, 2'd0, 0, 16'h0000, 16'h0072, "R2", 0);   // clears main, arms spare
        send(4'b0101, 2'd1, 0, 16'h0010, 16'h003C, "R4", 0);   // spare repair only
        send(4'b0101, 2'd3, 0, 16'h00F0, 16'h0079, "R1", 0);   // both repairs
        send(4'b1000, 2'd2, 0, 16'h0044, 16'h0011, "R7", 0);   // uncorrectable main
        send(4'b0100, 2'd2, 0, 16'h0044, 16'h0000, "R5", 0);   // flag was cleared
        send(4'b0100, 2'd0, 1, 16'h0055, 16'h0000, "R6", 0);   // spare-only blocks
        send(4'b0100, 2'd0, 0, 16'h0066, 16'h0000, "R6", 0);   // flag kept by spare-only
        send(4'b0110, 2'd1, 0, 16'h0E81, 16'h0022, "R7", 0);   // main fix + spare double
        send(4'b0100, 2'd2, 0, 16'h0123, 16'h0000, "R9", 1);   // poke while busy
        send(4'b0100, 2'd3, 0, 16'h0234, 16'h0000, "R9", 0);   // poke left flag set
        send(4'b1010, 2'd3, 0, 16'h0234, 16'h0005, "R7", 0);

        // R11: full sweep against the shadow copy
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < TOT; i++) begin
                @(negedge clk);
                host_addr = 11'(i);
                #1;
                if (host_rdata != shadow[i]) bad++;
            end
            chk(bad == 0, "R11", "RAM sweep mismatches", bad, 0);
        end
        finish_run();
    end

endmodule